// File: doc/BRIEF.md
# Address Generation and Next-PC Unit

This block computes, for a 16-bit word-addressed machine, the address that the memory address register should take and the value that the program counter should take next. Each evaluation uses the instruction word, the already-incremented program counter, two register-file read values (a base register and a jump register), the current negative/zero/positive flags, and a value from the shared data bus. The opcode in the top four bits of the instruction word selects the addressing mode and the program-counter source.

The address adder adds one base to one offset. The base is the incremented PC, the base register or the jump register. The offset is a sign-extended 9-bit field, a sign-extended 6-bit field, or zero. A two-way selector picks the memory address: either the adder sum or the zero-extended 8-bit trap vector. A three-way selector picks the next PC: the incremented PC, the adder sum, or the bus value. For conditional branches, the 3-bit condition mask is compared against the flags, and a one-bit indication reports whether the branch redirects the flow.

All results are held in output registers. The registers load on a rising clock edge while the evaluate enable is high. Results therefore appear one cycle after the inputs are presented.

Top module: `agu_npc_unit`

## Requirements
- R1: While reset is asserted (rst_n low), `ea_o`, `npc_o` and `br_taken_o` are all zero.
- R2: For opcodes 0x2, 0x3, 0xA, 0xB, 0xE and 0x0 (loads, stores, indirect forms, address-load and branch), `ea_o` is `pc_inc_i` plus ir[8:0] sign-extended, a range of -256 to +255. For every opcode except 0x0, 0x8, 0xC and 0xF, `npc_o` equals `pc_inc_i`.
- R3: For opcodes 0x6 and 0x7 (base+offset), `ea_o` is `base_i` plus ir[5:0] sign-extended, a range of -32 to +31.
- R4: For opcode 0x0, the branch is taken when the mask ir[11:9] ANDed with `flags_i` (bit 2 = N, bit 1 = Z, bit 0 = P) is non-zero. When taken, `npc_o` is `pc_inc_i` plus ir[8:0] sign-extended. When not taken, `npc_o` is `pc_inc_i`.
- R5: A branch mask of 000 is never taken. A mask of 111 is always taken when exactly one flag is set.
- R6: For opcode 0xC (register jump), both `npc_o` and `ea_o` equal `jreg_i`.
- R7: For opcode 0xF (trap), `ea_o` is ir[7:0] zero-extended to 16 bits and `npc_o` is `bus_i`. For opcode 0x8 (return from interrupt), `npc_o` is `bus_i`.
- R8: `br_taken_o` is high only after a taken opcode-0x0 evaluation. It is low for every other opcode.
- R9: The outputs update one clock edge after an evaluation with `eval_en` high. While `eval_en` is low, all outputs hold their values.
- R10: All address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| eval_en | input | 1 | Clock enable: capture a new evaluation |
| ir_i | input | 16 | Instruction word |
| pc_inc_i | input | 16 | Incremented program counter |
| base_i | input | 16 | Base register value for base+offset mode |
| jreg_i | input | 16 | Jump register value |
| bus_i | input | 16 | Shared bus value for bus-sourced PC loads |
| flags_i | input | 3 | Flags {N, Z, P} |
| ea_o | output | 16 | Memory address for MAR |
| npc_o | output | 16 | Next program counter |
| br_taken_o | output | 1 | Conditional branch taken |

## Verification
The bench targets several corner cases, each tied to a specific failure:
- Offsets at the extremes of both fields. A design that zero-extends an offset, or slices the wrong bits, produces a sum off by 512 or 64.
- Sums that cross 0xFFFF or go below 0x0000. These expose an adder that does not wrap.
- Every combination of branch mask and flags, including mask 000 and mask 111. An inverted or mis-ordered mask shows up as a wrong `npc_o` and a wrong taken bit.
- Jump, trap and return evaluations. These catch a swapped PC or MAR selector, because the design would then return the adder sum or the incremented PC.
- Cycles with `eval_en` low. These catch outputs that keep following the inputs.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [3:0] {
    OPC_BR   = 4'h0,
    OPC_ADD  = 4'h1,
    OPC_LD   = 4'h2,
    OPC_ST   = 4'h3,
    OPC_JSR  = 4'h4,
    OPC_AND  = 4'h5,
    OPC_LDR  = 4'h6,
    OPC_STR  = 4'h7,
    OPC_RTI  = 4'h8,
    OPC_NOT  = 4'h9,
    OPC_LDI  = 4'hA,
    OPC_STI  = 4'hB,
    OPC_JMP  = 4'hC,
    OPC_RSV  = 4'hD,
    OPC_LEA  = 4'hE,
    OPC_TRAP = 4'hF
  } opc_e;

  // next-PC source selector (three sources)
  typedef enum logic [1:0] {
    PCS_SEQ   = 2'd0,
    PCS_ADDER = 2'd1,
    PCS_BUS   = 2'd2
  } pc_src_e;

  // address-adder base operand
  typedef enum logic [1:0] {
    ABASE_PC   = 2'd0,
    ABASE_BREG = 2'd1,
    ABASE_JREG = 2'd2
  } addr_base_e;

  // address-adder offset operand
  typedef enum logic [1:0] {
    AOFF_LONG  = 2'd0,
    AOFF_SHORT = 2'd1,
    AOFF_ZERO  = 2'd2
  } addr_off_e;

  // memory-address source selector (two sources)
  typedef enum logic {
    MAR_ADDER  = 1'b0,
    MAR_VECTOR = 1'b1
  } mar_src_e;

  typedef struct packed {
    addr_base_e base_sel;
    addr_off_e  off_sel;
    pc_src_e    pc_sel;
    mar_src_e   mar_sel;
    logic       is_cond;
  } agu_ctl_t;

endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [3:0] opcode,
  output agu_ctl_t   ctl
);

  always_comb begin
    ctl.base_sel = ABASE_PC;
    ctl.off_sel  = AOFF_LONG;
    ctl.pc_sel   = PCS_SEQ;
    ctl.mar_sel  = MAR_ADDER;
    ctl.is_cond  = 1'b0;
    case (opcode)
      OPC_BR: begin
        ctl.pc_sel  = PCS_ADDER;
        ctl.is_cond = 1'b1;
      end
      OPC_LDR, OPC_STR: begin
        ctl.base_sel = ABASE_BREG;
        ctl.off_sel  = AOFF_SHORT;
      end
      OPC_JMP: begin
        ctl.base_sel = ABASE_JREG;
        ctl.off_sel  = AOFF_ZERO;
        ctl.pc_sel   = PCS_ADDER;
      end
      OPC_TRAP: begin
        ctl.mar_sel = MAR_VECTOR;
        ctl.pc_sel  = PCS_BUS;
      end
      OPC_RTI: begin
        ctl.pc_sel = PCS_BUS;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/agu_addr_adder.sv
module agu_addr_adder
  import agu_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int LONGOFF_W = 9,
  parameter int SHORTOFF_W = 6
) (
  input  logic [WORD_W-1:0]    pc_inc,
  input  logic [WORD_W-1:0]    base_val,
  input  logic [WORD_W-1:0]    jreg_val,
  input  logic [LONGOFF_W-1:0] off_field,
  input  addr_base_e           base_sel,
  input  addr_off_e            off_sel,
  output logic [WORD_W-1:0]    sum
);

  localparam int LONG_PAD  = WORD_W - LONGOFF_W;
  localparam int SHORT_PAD = WORD_W - SHORTOFF_W;

  logic [WORD_W-1:0] long_sx;
  logic [WORD_W-1:0] short_sx;
  logic [WORD_W-1:0] op_base;
  logic [WORD_W-1:0] op_off;

  assign long_sx  = {{LONG_PAD{off_field[LONGOFF_W-1]}}, off_field};
  assign short_sx = {{SHORT_PAD{off_field[SHORTOFF_W-1]}}, off_field[SHORTOFF_W-1:0]};

  always_comb begin
    case (base_sel)
      ABASE_BREG: op_base = base_val;
      ABASE_JREG: op_base = jreg_val;
      default:    op_base = pc_inc;
    endcase
  end

  always_comb begin
    case (off_sel)
      AOFF_SHORT: op_off = short_sx;
      AOFF_ZERO:  op_off = '0;
      default:    op_off = long_sx;
    endcase
  end

  // carry out discarded: modulo 2^WORD_W
  assign sum = op_base + op_off;

endmodule

// File: rtl/agu_cond.sv
module agu_cond #(
  parameter int FLAG_W = 3
) (
  input  logic [FLAG_W-1:0] mask,
  input  logic [FLAG_W-1:0] flags,
  output logic              hit
);

  logic [FLAG_W-1:0] match;

  for (genvar g = 0; g < FLAG_W; g++) begin : g_match
    assign match[g] = mask[g] & flags[g];
  end

  assign hit = |match;

endmodule

// File: rtl/agu_npc_unit.sv
module agu_npc_unit
  import agu_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int LONGOFF_W  = 9,
  parameter int SHORTOFF_W = 6,
  parameter int VEC_W      = 8,
  parameter int FLAG_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_en,
  input  logic [WORD_W-1:0] ir_i,
  input  logic [WORD_W-1:0] pc_inc_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [WORD_W-1:0] jreg_i,
  input  logic [WORD_W-1:0] bus_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [WORD_W-1:0] ea_o,
  output logic [WORD_W-1:0] npc_o,
  output logic              br_taken_o
);

  localparam int OPC_W    = 4;
  localparam int OPC_LSB  = WORD_W - OPC_W;
  localparam int MASK_LSB = LONGOFF_W;
  localparam int VEC_PAD  = WORD_W - VEC_W;

  agu_ctl_t          ctl;
  logic [WORD_W-1:0] adder_sum;
  logic              cond_hit;
  pc_src_e           pc_sel_eff;
  logic [WORD_W-1:0] vec_zx;

  logic [WORD_W-1:0] ea_d,  ea_q;
  logic [WORD_W-1:0] npc_d, npc_q;
  logic              tk_d,  tk_q;

  agu_decode u_dec (
    .opcode (ir_i[OPC_LSB +: OPC_W]),
    .ctl    (ctl)
  );

  agu_addr_adder #(
    .WORD_W     (WORD_W),
    .LONGOFF_W  (LONGOFF_W),
    .SHORTOFF_W (SHORTOFF_W)
  ) u_add (
    .pc_inc    (pc_inc_i),
    .base_val  (base_i),
    .jreg_val  (jreg_i),
    .off_field (ir_i[LONGOFF_W-1:0]),
    .base_sel  (ctl.base_sel),
    .off_sel   (ctl.off_sel),
    .sum       (adder_sum)
  );

  agu_cond #(
    .FLAG_W (FLAG_W)
  ) u_cond (
    .mask  (ir_i[MASK_LSB +: FLAG_W]),
    .flags (flags_i),
    .hit   (cond_hit)
  );

  assign vec_zx = {{VEC_PAD{1'b0}}, ir_i[VEC_W-1:0]};

  // next-state logic
  always_comb begin
    pc_sel_eff = (ctl.is_cond && !cond_hit) ? PCS_SEQ : ctl.pc_sel;
    case (pc_sel_eff)
      PCS_ADDER: npc_d = adder_sum;
      PCS_BUS:   npc_d = bus_i;
      default:   npc_d = pc_inc_i;
    endcase
    ea_d = (ctl.mar_sel == MAR_VECTOR) ? vec_zx : adder_sum;
    tk_d = ctl.is_cond & cond_hit;
  end

  // state registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      npc_q <= '0;
      tk_q  <= 1'b0;
    end else if (eval_en) begin
      ea_q  <= ea_d;
      npc_q <= npc_d;
      tk_q  <= tk_d;
    end
  end

  assign ea_o       = ea_q;
  assign npc_o      = npc_q;
  assign br_taken_o = tk_q;

endmodule

// File: rtl/agu_npc_chk.sv
module agu_npc_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eval_en,
  input logic [WORD_W-1:0] ir_i,
  input logic [WORD_W-1:0] pc_inc_i,
  input logic [WORD_W-1:0] jreg_i,
  input logic [WORD_W-1:0] bus_i,
  input logic [2:0]        flags_i,
  input logic [WORD_W-1:0] ea_o,
  input logic [WORD_W-1:0] npc_o,
  input logic              br_taken_o
);

  logic [3:0]        opc;
  logic [2:0]        msk;
  logic [WORD_W-1:0] tgt;

  assign opc = ir_i[WORD_W-1 -: 4];
  assign msk = ir_i[11:9];
  assign tgt = pc_inc_i + {{(WORD_W-9){ir_i[8]}}, ir_i[8:0]};

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_en |=> ($stable(ea_o) && $stable(npc_o) && $stable(br_taken_o)));

  p_taken_only_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && opc != 4'h0) |=> !br_taken_o);

  p_branch_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && opc == 4'h0 && (msk & flags_i) != 3'b000) |=> (br_taken_o && npc_o == $past(tgt)));

  p_mask_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && opc == 4'h0 && msk == 3'b000) |=> (!br_taken_o && npc_o == $past(pc_inc_i)));

  p_mask_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && opc == 4'h0 && msk == 3'b111 && $onehot(flags_i)) |=> br_taken_o);

  p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && opc == 4'hC) |=> (npc_o == $past(jreg_i) && ea_o == $past(jreg_i)));

  p_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && opc == 4'hF) |=> (ea_o == {{(WORD_W-8){1'b0}}, $past(ir_i[7:0])} && npc_o == $past(bus_i)));

endmodule

bind agu_npc_unit agu_npc_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eval_en    (eval_en),
  .ir_i       (ir_i),
  .pc_inc_i   (pc_inc_i),
  .jreg_i     (jreg_i),
  .bus_i      (bus_i),
  .flags_i    (flags_i),
  .ea_o       (ea_o),
  .npc_o      (npc_o),
  .br_taken_o (br_taken_o)
);

// File: tb/agu_npc_unit_tb_top.sv
module agu_npc_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        eval_en;
  logic [15:0] ir_i, pc_inc_i, base_i, jreg_i, bus_i;
  logic [2:0]  flags_i;
  logic [15:0] ea_o, npc_o;
  logic        br_taken_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [15:0] exp_ea, exp_npc;
  logic        exp_tk;

  agu_npc_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_en    (eval_en),
    .ir_i       (ir_i),
    .pc_inc_i   (pc_inc_i),
    .base_i     (base_i),
    .jreg_i     (jreg_i),
    .bus_i      (bus_i),
    .flags_i    (flags_i),
    .ea_o       (ea_o),
    .npc_o      (npc_o),
    .br_taken_o (br_taken_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [15:0] sx9(input logic [15:0] ir);
    return {{7{ir[8]}}, ir[8:0]};
  endfunction

  function automatic logic [15:0] sx6(input logic [15:0] ir);
    return {{10{ir[5]}}, ir[5:0]};
  endfunction

  // reference model from the requirements
  task automatic model();
    logic [3:0] op;
    logic       hit;
    op  = ir_i[15:12];
    hit = (ir_i[11:9] & flags_i) != 3'b000;
    case (op)
      4'h6, 4'h7: exp_ea = base_i + sx6(ir_i);          // R3
      4'hC:       exp_ea = jreg_i;                      // R6
      4'hF:       exp_ea = {8'h00, ir_i[7:0]};          // R7
      default:    exp_ea = pc_inc_i + sx9(ir_i);        // R2
    endcase
    case (op)
      4'h0:       exp_npc = hit ? pc_inc_i + sx9(ir_i) : pc_inc_i;  // R4
      4'hC:       exp_npc = jreg_i;
      4'h8, 4'hF: exp_npc = bus_i;
      default:    exp_npc = pc_inc_i;
    endcase
    exp_tk = (op == 4'h0) && hit;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [15:0] ir, input logic [15:0] pc,
                     input logic [15:0] bse, input logic [15:0] jr, input logic [15:0] bus,
                     input logic [2:0] fl);
    @(negedge clk);
    eval_en  = 1'b1;
    ir_i     = ir;
    pc_inc_i = pc;
    base_i   = bse;
    jreg_i   = jr;
    bus_i    = bus;
    flags_i  = fl;
    model();
    @(posedge clk);
    #1;
    check({req, " ea"}, ea_o, exp_ea);
    check({req, " npc"}, npc_o, exp_npc);
    check({req, " taken"}, {15'd0, br_taken_o}, {15'd0, exp_tk});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n    = 1'b0;
    eval_en  = 1'b1;
    ir_i     = 16'hE1FF;
    pc_inc_i = 16'h1234;
    base_i   = 16'h4321;
    jreg_i   = 16'hAAAA;
    bus_i    = 16'h5555;
    flags_i  = 3'b010;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset holds outputs at zero
    check("R1 ea",  ea_o,  16'h0000);
    check("R1 npc", npc_o, 16'h0000);
    check("R1 taken", {15'd0, br_taken_o}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: PC-relative extremes
    run("R2 lea -256",   16'hE300, 16'h3000, 16'h0, 16'h0, 16'h0, 3'b001);
    run("R2 ld +255",    16'h20FF, 16'h3000, 16'h0, 16'h0, 16'h0, 3'b001);
    run("R2 sti",        16'hB1F0, 16'h4000, 16'h0, 16'h0, 16'h0, 3'b100);
    // R10: wrap
    run("R10 ld wrap up",   16'h20FF, 16'hFFF0, 16'h0, 16'h0, 16'h0, 3'b010);
    run("R10 lea wrap down",16'hE100, 16'h0010, 16'h0, 16'h0, 16'h0, 3'b010);
    // R3: base+offset
    run("R3 ldr -32 wrap", 16'h6020, 16'h3000, 16'h0005, 16'h0, 16'h0, 3'b001);
    run("R3 str +31",      16'h701F, 16'h3000, 16'h1000, 16'h0, 16'h0, 3'b001);
    // R4/R5: branches
    run("R4 br z taken",    16'h0405, 16'h3005, 16'h0, 16'h0, 16'h0, 3'b010);
    run("R4 br z not taken",16'h0405, 16'h3005, 16'h0, 16'h0, 16'h0, 3'b100);
    run("R4 br np back",    16'h0BFA, 16'h300A, 16'h0, 16'h0, 16'h0, 3'b001);
    for (int f = 0; f < 3; f++) begin
      run("R5 mask none", 16'h01FF, 16'h2000, 16'h0, 16'h0, 16'h0, 3'(1 << f));
      run("R5 mask all",  16'h0E10, 16'h2000, 16'h0, 16'h0, 16'h0, 3'(1 << f));
    end
    // R6/R7
    run("R6 jmp",  16'hC0C0, 16'h3000, 16'h0, 16'hBEEF, 16'h0, 3'b001);
    run("R7 trap", 16'hF025, 16'h3011, 16'h0, 16'h0, 16'h0400, 3'b001);
    run("R7 rti",  16'h8000, 16'h3011, 16'h0, 16'h0, 16'h3012, 3'b001);
    // R8: non-branch opcodes, taken low
    run("R8 add", 16'h1421, 16'h3003, 16'h0, 16'h0, 16'h0, 3'b111);

    // R9: hold while enable low
    @(negedge clk);
    eval_en  = 1'b0;
    ir_i     = 16'hC1C0;
    jreg_i   = 16'h7777;
    bus_i    = 16'h9999;
    repeat (2) @(posedge clk);
    #1;
    check("R9 hold ea",  ea_o,  exp_ea);
    check("R9 hold npc", npc_o, exp_npc);
    check("R9 hold taken", {15'd0, br_taken_o}, {15'd0, exp_tk});

    // random mix over all opcodes
    for (int i = 0; i < 400; i++) begin
      run("R2-mix random",
          16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
          3'(1 << ($urandom % 3)));
    end
    finish_run();
  end

endmodule